// File: doc/BRIEF.md
# Ethernet MAC Event Counter Bank

This block holds one wide event counter per statistic kept by a 10 Gb/s Ethernet MAC: frame counts by class and by error type for both directions, and a good-octet total for each direction. The receive and transmit datapaths drive one strobe per counter. They can also drive a second strobe to the same counter, so two frame events that land in one statistic count together. The two octet counters take the frame's byte count in place of a unit increment.

Software reaches the bank over a plain 16-bit register bus. A write to the command register freezes every live counter into a holding bank in one cycle. Each held value is then read in 16-bit words while counting goes on. A second command bit zeroes all live counters. When a counter passes its maximum it wraps, and this sets that counter's bit in a rollover bitmap. Software reads the bitmap as four 16-bit words, and a read clears the word it returns. Software adds these wraps to its own wider totals.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset every live counter, every held value and every rollover bit is zero, and the read data output is zero.
- R2: A counter that is not an octet counter adds, each cycle, the number of its two strobes (`ev_hit`, `ev_aux`) that are high: 0, 1 or 2.
- R3: The receive octet counter (slot `RX_OCT_SLOT`) adds `rx_bytes`, and the transmit octet counter (slot `TX_OCT_SLOT`) adds `tx_bytes`, in any cycle where either of its strobes is high. If both strobes are high in one cycle, the byte count is added once.
- R4: A write to `CTRL_ADDR` with bit 0 set copies all live counters into the holding bank. The copy takes each value as it stood before that cycle's events. Held values do not change until the next snapshot, even while the live counters keep counting.
- R5: Held counter `i` is read at `CNT_BASE + 4*i + w`. Word w=0 returns bits 15:0, w=1 bits 31:16, and w=2 bits 47:32 (bits 39:32 in the low byte for a 40-bit counter). Bits above the counter width read as zero, and w=3 reads zero. `bus_rdata` updates on the clock edge that samples `bus_rd` and then holds until the next read.
- R6: A write to `CTRL_ADDR` with bit 1 set zeroes every live counter. Events in that cycle are dropped. A snapshot requested in the same write captures the values from before the clear. The rollover bits are left unchanged.
- R7: Counters count modulo 2^CNT_W. A wrap sets rollover bit `i` for slot `i`. Bit `i` is bit `i%16` of the rollover word at `ROLL_BASE + i/16`. Reaching the maximum value exactly does not set the bit.
- R8: A read of a rollover word returns its bits and clears them. A wrap that occurs in the same cycle as the read stays set.
- R9: The command address, unused rollover words and addresses past the last slot read as zero. Writes to counter or rollover addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_hit | input | NUM_CNT | Primary event strobe, one per counter |
| ev_aux | input | NUM_CNT | Secondary event strobe, one per counter |
| rx_bytes | input | BYTE_W | Byte count for the receive octet counter |
| tx_bytes | input | BYTE_W | Byte count for the transmit octet counter |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |

## Verification
The bench builds the bank with 20 counters that are 20 bits wide. With a 16-bit byte count, the octet counters can therefore be driven to their maximum and past it within a few dozen cycles. This makes the exact-maximum boundary, the wrap itself and a wrap that coincides with a bitmap read all reachable. Twenty slots place the transmit octet counter at slot 17, so its rollover bit falls in the second bitmap word. The upper word of a slot carries only four live bits, so the zero fill above the counter width is checked as well.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  localparam int unsigned BUS_W      = 16;
  localparam int unsigned ROLL_WORDS = 4;
  localparam int unsigned ROLL_BITS  = ROLL_WORDS * BUS_W;
  localparam int unsigned SLOT_WORDS = 4;
  localparam int unsigned WIDE_W     = SLOT_WORDS * BUS_W;
endpackage

// File: rtl/mstat_counter.sv
module mstat_counter #(
  parameter int unsigned CNT_W   = 40,
  parameter int unsigned DELTA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic [DELTA_W-1:0] delta,
  output logic [CNT_W-1:0]   value,
  output logic               wrap
);
  logic [CNT_W:0] sum_ext;

  always_comb sum_ext = {1'b0, value} + (CNT_W+1)'(delta);

  assign wrap = sum_ext[CNT_W] & ~clr;

  always_ff @(posedge clk) begin
    if (rst || clr) value <= '0;
    else            value <= sum_ext[CNT_W-1:0];
  end

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (value == '0));

  assert_wrap_drop_R7: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (value < $past(value)));
endmodule

// File: rtl/mstat_rollover.sv
module mstat_rollover import mstat_pkg::*; #(
  parameter int unsigned NUM_CNT = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CNT-1:0]   wrap,
  input  logic                 rd_en,
  input  logic [1:0]           rd_word,
  output logic [ROLL_BITS-1:0] roll_bits
);
  logic [NUM_CNT-1:0] roll;
  logic [NUM_CNT-1:0] clr_mask;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_bit
    localparam int unsigned WORD_IDX = i / BUS_W;
    assign clr_mask[i] = rd_en && (rd_word == 2'(WORD_IDX));
    always_ff @(posedge clk) begin
      if (rst) roll[i] <= 1'b0;
      else     roll[i] <= (roll[i] & ~clr_mask[i]) | wrap[i];
    end
  end

  assign roll_bits = ROLL_BITS'(roll);

  assert_wrap_sets_R7: assert property (@(posedge clk) disable iff (rst)
    (wrap != '0) |=> ((roll & $past(wrap)) == $past(wrap)));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (wrap == '0)) |=>
      (((roll_bits >> (BUS_W * $past(rd_word))) & ROLL_BITS'(16'hFFFF)) == '0));
endmodule

// File: rtl/mstat_regif.sv
module mstat_regif import mstat_pkg::*; #(
  parameter int unsigned NUM_CNT   = 24,
  parameter int unsigned CNT_W     = 40,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned CTRL_ADDR = 'h000,
  parameter int unsigned ROLL_BASE = 'h010,
  parameter int unsigned CNT_BASE  = 'h040
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [BUS_W-1:0]         bus_wdata,
  input  logic                     bus_rd,
  input  logic [NUM_CNT*CNT_W-1:0] snap_flat,
  input  logic [ROLL_BITS-1:0]     roll_bits,
  output logic                     snap_cmd,
  output logic                     clr_cmd,
  output logic                     roll_rd,
  output logic [1:0]               roll_word,
  output logic [BUS_W-1:0]         bus_rdata
);
  logic [ADDR_W-1:0] cnt_off, roll_off;
  logic              in_cnt, in_roll, is_ctrl;
  logic [CNT_W-1:0]  slot_val;
  logic [WIDE_W-1:0] wide;
  logic [BUS_W-1:0]  rd_val;
  logic [BUS_W-3:0]  unused_wdata;

  assign unused_wdata = bus_wdata[BUS_W-1:2];
  assign cnt_off  = bus_addr - ADDR_W'(CNT_BASE);
  assign roll_off = bus_addr - ADDR_W'(ROLL_BASE);
  assign in_cnt   = (bus_addr >= ADDR_W'(CNT_BASE)) &&
                    (int'(cnt_off[ADDR_W-1:2]) < NUM_CNT);
  assign in_roll  = (bus_addr >= ADDR_W'(ROLL_BASE)) &&
                    (roll_off < ADDR_W'(ROLL_WORDS));
  assign is_ctrl  = (bus_addr == ADDR_W'(CTRL_ADDR));

  assign snap_cmd  = bus_wr && is_ctrl && bus_wdata[0];
  assign clr_cmd   = bus_wr && is_ctrl && bus_wdata[1];
  assign roll_rd   = bus_rd && in_roll;
  assign roll_word = roll_off[1:0];

  always_comb begin
    slot_val = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (int'(cnt_off[ADDR_W-1:2]) == i) slot_val = snap_flat[i*CNT_W +: CNT_W];
    wide = WIDE_W'(slot_val);
    rd_val = '0;
    if (in_cnt) begin
      if (cnt_off[1:0] != 2'd3) rd_val = wide[cnt_off[1:0]*BUS_W +: BUS_W];
    end else if (in_roll) begin
      rd_val = roll_bits[roll_word*BUS_W +: BUS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !in_cnt && !in_roll) |=> (bus_rdata == '0));
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank import mstat_pkg::*; #(
  parameter int unsigned NUM_CNT     = 24,
  parameter int unsigned CNT_W       = 40,
  parameter int unsigned BYTE_W      = 16,
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned RX_OCT_SLOT = 0,
  parameter int unsigned TX_OCT_SLOT = 12,
  parameter int unsigned CTRL_ADDR   = 'h000,
  parameter int unsigned ROLL_BASE   = 'h010,
  parameter int unsigned CNT_BASE    = 'h040
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] ev_hit,
  input  logic [NUM_CNT-1:0] ev_aux,
  input  logic [BYTE_W-1:0]  rx_bytes,
  input  logic [BYTE_W-1:0]  tx_bytes,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [15:0]        bus_wdata,
  input  logic               bus_rd,
  output logic [15:0]        bus_rdata
);
  logic [BYTE_W-1:0]        delta [NUM_CNT];
  logic [NUM_CNT*CNT_W-1:0] cnt_flat, snap_flat;
  logic [NUM_CNT-1:0]       wrap;
  logic [ROLL_BITS-1:0]     roll_bits;
  logic                     snap_cmd, clr_cmd, roll_rd;
  logic [1:0]               roll_word;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    if (i == RX_OCT_SLOT) begin : g_rx_oct
      assign delta[i] = (ev_hit[i] | ev_aux[i]) ? rx_bytes : '0;
    end else if (i == TX_OCT_SLOT) begin : g_tx_oct
      assign delta[i] = (ev_hit[i] | ev_aux[i]) ? tx_bytes : '0;
    end else begin : g_frame
      assign delta[i] = BYTE_W'(ev_hit[i]) + BYTE_W'(ev_aux[i]);
    end

    mstat_counter #(.CNT_W(CNT_W), .DELTA_W(BYTE_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr_cmd),
      .delta (delta[i]),
      .value (cnt_flat[i*CNT_W +: CNT_W]),
      .wrap  (wrap[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)           snap_flat <= '0;
    else if (snap_cmd) snap_flat <= cnt_flat;
  end

  mstat_rollover #(.NUM_CNT(NUM_CNT)) u_roll (
    .clk       (clk),
    .rst       (rst),
    .wrap      (wrap),
    .rd_en     (roll_rd),
    .rd_word   (roll_word),
    .roll_bits (roll_bits)
  );

  mstat_regif #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .CTRL_ADDR(CTRL_ADDR), .ROLL_BASE(ROLL_BASE), .CNT_BASE(CNT_BASE)
  ) u_regif (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .snap_flat (snap_flat),
    .roll_bits (roll_bits),
    .snap_cmd  (snap_cmd),
    .clr_cmd   (clr_cmd),
    .roll_rd   (roll_rd),
    .roll_word (roll_word),
    .bus_rdata (bus_rdata)
  );

  assert_snap_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !snap_cmd |=> $stable(snap_flat));
endmodule

// File: tb/sim_mac_stat_bank.sv
module sim_mac_stat_bank;
  localparam int NUM  = 20;
  localparam int CW   = 20;
  localparam int BW   = 16;
  localparam int AW   = 10;
  localparam int RXS  = 0;
  localparam int TXS  = 17;
  localparam int CTRL = 'h000;
  localparam int RB   = 'h010;
  localparam int CB   = 'h040;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM-1:0] ev_hit = '0, ev_aux = '0;
  logic [BW-1:0]  rx_bytes = '0, tx_bytes = '0;
  logic [AW-1:0]  bus_addr = '0;
  logic           bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0]    bus_wdata = '0;
  logic [15:0]    bus_rdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mac_stat_bank #(
    .NUM_CNT(NUM), .CNT_W(CW), .BYTE_W(BW), .ADDR_W(AW),
    .RX_OCT_SLOT(RXS), .TX_OCT_SLOT(TXS),
    .CTRL_ADDR(CTRL), .ROLL_BASE(RB), .CNT_BASE(CB)
  ) u0 (
    .clk(clk), .rst(rst), .ev_hit(ev_hit), .ev_aux(ev_aux),
    .rx_bytes(rx_bytes), .tx_bytes(tx_bytes), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int addr, input logic [15:0] data);
    @(negedge clk);
    bus_addr = AW'(addr); bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int addr, output logic [15:0] data);
    @(negedge clk);
    bus_addr = AW'(addr); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    data = bus_rdata;
  endtask

  task automatic pulse(input logic [NUM-1:0] h, input logic [NUM-1:0] a,
                       input logic [BW-1:0] rb, input logic [BW-1:0] tb);
    @(negedge clk);
    ev_hit = h; ev_aux = a; rx_bytes = rb; tx_bytes = tb;
    @(negedge clk);
    ev_hit = '0; ev_aux = '0; rx_bytes = '0; tx_bytes = '0;
  endtask

  task automatic read_held(input int slot, output longint val);
    logic [15:0] w0, w1, w2;
    bus_read(CB + 4*slot, w0);
    bus_read(CB + 4*slot + 1, w1);
    bus_read(CB + 4*slot + 2, w2);
    val = longint'(w0) | (longint'(w1) << 16) | (longint'(w2) << 32);
  endtask

  task automatic read_live(input int slot, output longint val);
    bus_write(CTRL, 16'h0001);
    read_held(slot, val);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    longint v;
    check("R1 rdata after reset", longint'(bus_rdata), 0);
    read_held(3, v);
    check("R1 held value after reset", v, 0);
    read_live(TXS, v);
    check("R1 live counter after reset", v, 0);
    bus_read(RB, d);
    check("R1 rollover after reset", longint'(d), 0);
  endtask

  task automatic t_frame;
    longint v;
    bus_write(CTRL, 16'h0002);
    for (int k = 0; k < 3; k++) pulse(NUM'(1) << 3, '0, 0, 0);
    for (int k = 0; k < 2; k++) pulse(NUM'(1) << 3, NUM'(1) << 3, 0, 0);
    pulse('0, NUM'(1) << 3, 0, 0);
    read_live(3, v);
    check("R2 summed strobes slot 3", v, 8);
    pulse('1, '0, 10, 10);
    read_live(3, v);
    check("R2 all strobes slot 3", v, 9);
    read_held(19, v);
    check("R2 all strobes last slot", v, 1);
    read_held(RXS, v);
    check("R3 all strobes rx octets", v, 10);
  endtask

  task automatic t_octet;
    longint v;
    bus_write(CTRL, 16'h0002);
    pulse(NUM'(1) << RXS, '0, 100, 0);
    pulse(NUM'(1) << RXS, '0, 1500, 0);
    pulse('0, NUM'(1) << RXS, 77, 0);
    pulse(NUM'(1) << RXS, NUM'(1) << RXS, 23, 0);
    pulse(NUM'(1) << TXS, '0, 999, 64);
    pulse(NUM'(1) << TXS, '0, 999, 64);
    read_live(RXS, v);
    check("R3 rx octet sum", v, 1700);
    read_held(TXS, v);
    check("R3 tx octet sum", v, 128);
  endtask

  task automatic t_snapshot;
    longint v;
    bus_write(CTRL, 16'h0002);
    for (int k = 0; k < 5; k++) pulse(NUM'(1) << 2, '0, 0, 0);
    @(negedge clk);
    bus_addr = AW'(CTRL); bus_wdata = 16'h0001; bus_wr = 1'b1; ev_hit = NUM'(1) << 2;
    @(negedge clk);
    bus_wr = 1'b0; ev_hit = '0;
    read_held(2, v);
    check("R4 snapshot excludes same-cycle event", v, 5);
    for (int k = 0; k < 3; k++) pulse(NUM'(1) << 2, '0, 0, 0);
    read_held(2, v);
    check("R4 held value stable while counting", v, 5);
    read_live(2, v);
    check("R4 new snapshot", v, 9);
  endtask

  task automatic t_layout;
    logic [15:0] d;
    bus_write(CTRL, 16'h0002);
    pulse(NUM'(1) << RXS, '0, 16'hFFFF, 0);
    pulse(NUM'(1) << RXS, '0, 16'h2346, 0);
    pulse(NUM'(1) << 19, '0, 0, 0);
    bus_write(CTRL, 16'h0001);
    bus_read(CB + 4*RXS, d);
    check("R5 word0 low bits", longint'(d), 'h2345);
    bus_read(CB + 4*RXS + 1, d);
    check("R5 word1 upper bits", longint'(d), 'h0001);
    bus_read(CB + 4*RXS + 2, d);
    check("R5 word2 above width", longint'(d), 0);
    bus_read(CB + 4*RXS + 3, d);
    check("R5 word3 reads zero", longint'(d), 0);
    bus_read(CB + 4*19, d);
    check("R5 last slot address", longint'(d), 1);
  endtask

  task automatic t_clear;
    longint v;
    bus_write(CTRL, 16'h0002);
    for (int k = 0; k < 4; k++) pulse(NUM'(1) << 3, '0, 0, 0);
    @(negedge clk);
    bus_addr = AW'(CTRL); bus_wdata = 16'h0003; bus_wr = 1'b1; ev_hit = NUM'(1) << 3;
    @(negedge clk);
    bus_wr = 1'b0; ev_hit = '0;
    read_held(3, v);
    check("R6 snapshot with clear sees old value", v, 4);
    read_live(3, v);
    check("R6 counter cleared, same-cycle event dropped", v, 0);
  endtask

  task automatic t_wrap;
    logic [15:0] d;
    longint v;
    bus_write(CTRL, 16'h0002);
    for (int k = 0; k < 16; k++) pulse(NUM'(1) << RXS, '0, 16'hFFFF, 0);
    pulse(NUM'(1) << RXS, '0, 15, 0);
    bus_read(RB, d);
    check("R7 no rollover at exact maximum", longint'(d), 0);
    pulse(NUM'(1) << RXS, '0, 3, 0);
    read_live(RXS, v);
    check("R7 counter wraps modulo width", v, 2);
    bus_write(CTRL, 16'h0002);
    bus_read(RB, d);
    check("R6 clear leaves rollover bit", longint'(d), 'h0001);
    bus_read(RB, d);
    check("R8 read cleared rollover word", longint'(d), 0);
    for (int k = 0; k < 16; k++) pulse(NUM'(1) << TXS, '0, 0, 16'hFFFF);
    pulse(NUM'(1) << TXS, '0, 0, 16'h0010);
    bus_read(RB, d);
    check("R7 word0 untouched by slot 17 wrap", longint'(d), 0);
  endtask

  task automatic t_race;
    logic [15:0] d;
    for (int k = 0; k < 16; k++) pulse(NUM'(1) << TXS, '0, 0, 16'hFFFF);
    @(negedge clk);
    bus_addr = AW'(RB + 1); bus_rd = 1'b1; ev_hit = NUM'(1) << TXS; tx_bytes = 16'h0010;
    @(negedge clk);
    bus_rd = 1'b0; ev_hit = '0; tx_bytes = '0;
    check("R7 slot 17 in word1 bit1", longint'(bus_rdata), 'h0002);
    bus_read(RB + 1, d);
    check("R8 wrap during read stays set", longint'(d), 'h0002);
    bus_read(RB + 1, d);
    check("R8 cleared after second read", longint'(d), 0);
  endtask

  task automatic t_unmapped;
    logic [15:0] d;
    longint v;
    bus_write(CTRL, 16'h0002);
    pulse(NUM'(1) << 3, '0, 0, 0);
    pulse(NUM'(1) << 3, '0, 0, 0);
    bus_write(CTRL, 16'h0001);
    bus_write(CB + 12, 16'hFFFF);
    bus_write(RB, 16'hFFFF);
    read_live(3, v);
    check("R9 counter write ignored", v, 2);
    bus_read(RB, d);
    check("R9 rollover write ignored", longint'(d), 0);
    bus_read(CTRL, d);
    check("R9 command address reads zero", longint'(d), 0);
    bus_read(CB + 4*NUM, d);
    check("R9 past last slot reads zero", longint'(d), 0);
    bus_read(RB + 4, d);
    check("R9 beyond rollover words reads zero", longint'(d), 0);
    bus_read(RB + 3, d);
    check("R9 unused rollover word reads zero", longint'(d), 0);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_frame();
    t_octet();
    t_snapshot();
    t_layout();
    t_clear();
    t_wrap();
    t_race();
    t_unmapped();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule